// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs read and write cycles on an external bus where one set of pins carries first the address and then the data. A core places a request (address, write data, byte or word size, direction) and holds it. The block then produces the address strobe, the read strobe and two write-type strobes, and drives or samples the shared bus. When the transfer is finished it raises `done` for one clock, and read data is valid at that point. The block runs from the oscillator clock and produces a bus clock output at half that rate. Every bus cycle starts on a rising edge of that output and lasts a whole number of its periods.

The width of each physical cycle can be taken from an input pin, which is sampled during the address clock. A word request that meets an 8-bit cycle is split into two byte cycles, with the low byte first. A slow device can stretch a cycle by holding `ready` low. Each low sample adds one bus-clock period, which is two oscillator clocks. Two strobe encodings are offered: a write strobe plus high-byte enable, or separate even-byte and odd-byte write strobes. Two address strobe styles are offered: a one-clock latch pulse, or an address-valid level that rises again at the end of the cycle.

The sequencer has seven states. S_IDLE goes to S_ADDR when a request is present and the bus clock output is low. S_ADDR always goes to S_CMD1. S_CMD1 goes to S_CMD2 when `ready` is high and to S_WAITA when it is low. S_WAITA always goes to S_WAITB. S_WAITB goes to S_CMD2 when `ready` is high and back to S_WAITA when it is low. S_CMD2 always goes to S_CLOSE. S_CLOSE goes to S_ADDR to run the high-byte part of a split word, and to S_IDLE otherwise.

Top module: `mux_bus_seq`

## Requirements
- R1: While `rst_n` is low: `rd_n`, `wr_n` and `bhe_n` are 1, `done` is 0, `ad_oe` is 0, and `addr_strobe` equals `addr_mode`.
- R2: Each physical cycle opens with one clock in which `ad_oe` is 1 and `ad_out` carries the cycle address. With `addr_mode`=0, `addr_strobe` is 1 in exactly that clock. With `addr_mode`=1, `addr_strobe` falls at that clock, stays 0 through the command clocks, and returns to 1 in the cycle's last clock.
- R3: `clk_out` toggles every clock from 0 after reset. It is 1 in every address clock. A cycle with no waits lasts 4 clocks, and its command strobe is low for the middle 2.
- R4: `ready` is sampled at the clock edges where `clk_out` rises during the command phase. Each low sample adds 2 clocks of strobe-low time, so the strobe is low for 2+2·waits clocks.
- R5: With `dyn_width_en`=1, `bus_width` is sampled at the end of the address clock: 0 gives an 8-bit cycle and 1 gives a 16-bit cycle. With `dyn_width_en`=0 every cycle is 16-bit.
- R6: `rd_n` is low only in read cycles. Read data is taken at the last strobe-low clock. On a 16-bit cycle an odd byte comes from `ad_in[15:8]` and an even byte from `ad_in[7:0]`. On an 8-bit cycle every byte comes from `ad_in[7:0]`.
- R7: With `strobe_mode`=0, `wr_n` is low on every write strobe clock, and `bhe_n` is low when the cycle writes the odd-addressed byte.
- R8: With `strobe_mode`=1, `wr_n` is low only when the cycle writes the even-addressed byte, and `bhe_n` only when it writes the odd-addressed byte. A word on a 16-bit cycle writes both.
- R9: A word request (even address A) on an 8-bit cycle runs two cycles, to A and then to A|1, with no idle clock between them.
- R10: `done` is high for exactly one clock, the last clock of the final cycle. `rdata` then holds {byte(A|1), byte(A)} for a word read, or {8'h00, byte(A)} for a byte read.
- R11: During write command clocks `ad_oe` is 1. `ad_out` carries the full word for a 16-bit word cycle, and otherwise carries the current byte on both lanes (the low write byte first, the high write byte in the second part of a split).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_mode | input | 1 | 0 = latch pulse, 1 = address-valid level |
| strobe_mode | input | 1 | 0 = write + high-byte enable, 1 = even/odd write strobes |
| dyn_width_en | input | 1 | 1 = take cycle width from `bus_width` |
| req_valid | input | 1 | Request present, held until `done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word (even address), 0 = byte |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data |
| ready | input | 1 | Low inserts wait states |
| bus_width | input | 1 | Width of the current cycle (1 = 16-bit) |
| ad_in | input | 16 | Bus input lanes |
| ad_out | output | 16 | Bus output lanes (address, then write data) |
| ad_oe | output | 1 | Bus output enable |
| clk_out | output | 1 | Bus clock output, half the oscillator rate |
| addr_strobe | output | 1 | Address latch / address-valid strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe or even-byte write strobe, active low |
| bhe_n | output | 1 | High-byte enable or odd-byte write strobe, active low |
| rdata | output | 16 | Read result, valid while `done` is high |
| done | output | 1 | One-clock completion pulse |

## Verification
The assertions rely on the core holding `req_valid` and the request fields steady from acceptance until `done`, and on word requests always using even addresses. They also take `ready` and `bus_width` to be synchronous to `clk`. The stimulus drives requests only from a task that changes them on falling clock edges, keeps word addresses even, and drops `req_valid` on the clock where `done` is seen. The bus model changes `ready`, `bus_width` and `ad_in` only on falling edges. It picks each cycle's width and wait count when it sees the address phase. The mode inputs are changed only while the bus is idle.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_CMD1,
        S_WAITA,
        S_WAITB,
        S_CMD2,
        S_CLOSE
    } bus_state_t;

endpackage

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
    import mux_bus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       ready,
    input  logic       need_split,
    output bus_state_t state,
    output logic       clk_out,
    output logic       start,
    output logic       second
);

    bus_state_t nxt;

    // a cycle may only open when the bus clock is about to rise
    assign start = (state == S_IDLE) && req_valid && !clk_out;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            clk_out <= 1'b0;
            second  <= 1'b0;
        end else begin
            state   <= nxt;
            clk_out <= ~clk_out;
            if (start)
                second <= 1'b0;
            else if (state == S_CLOSE && need_split)
                second <= 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  nxt = start ? S_ADDR : S_IDLE;
            S_ADDR:  nxt = S_CMD1;
            S_CMD1:  nxt = ready ? S_CMD2 : S_WAITA;
            S_WAITA: nxt = S_WAITB;
            S_WAITB: nxt = ready ? S_CMD2 : S_WAITA;
            S_CMD2:  nxt = S_CLOSE;
            S_CLOSE: nxt = need_split ? S_ADDR : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // address clock always sits on the high half of the bus clock
    assert_addr_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR) |-> clk_out);

    // a wait is entered only after ready was sampled low
    assert_wait_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAITA) |-> !$past(ready));

    // the high-byte part follows straight on from the low-byte close
    assert_split_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && second) |-> ($past(state) == S_CLOSE));

endmodule

// File: rtl/bus_lane_path.sv
module bus_lane_path
    import mux_bus_pkg::*;
#(
    parameter int AD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  bus_state_t      state,
    input  logic            second,
    input  logic            req_write,
    input  logic            req_word,
    input  logic [AD_W-1:0] req_addr,
    input  logic [AD_W-1:0] req_wdata,
    input  logic            dyn_width_en,
    input  logic            bus_width,
    input  logic [AD_W-1:0] ad_in,
    output logic [AD_W-1:0] ad_out,
    output logic            ad_oe,
    output logic [AD_W-1:0] rdata,
    output logic            cyc_write,
    output logic            even_sel,
    output logic            odd_sel,
    output logic            need_split
);

    localparam int BYTE_W = AD_W / 2;

    logic [AD_W-1:0]   cyc_addr;
    logic [AD_W-1:0]   lat_wdata;
    logic              lat_word;
    logic              wide;
    logic              xfer_word;
    logic [BYTE_W-1:0] wr_byte;
    logic [BYTE_W-1:0] rd_byte;
    logic              in_cmd;

    assign xfer_word  = lat_word && wide && !second;
    assign need_split = lat_word && !wide && !second;
    assign even_sel   = xfer_word || !cyc_addr[0];
    assign odd_sel    = xfer_word || cyc_addr[0];
    assign wr_byte    = second ? lat_wdata[AD_W-1:BYTE_W] : lat_wdata[BYTE_W-1:0];
    assign rd_byte    = (wide && cyc_addr[0]) ? ad_in[AD_W-1:BYTE_W] : ad_in[BYTE_W-1:0];
    assign in_cmd     = (state == S_CMD1) || (state == S_WAITA) || (state == S_WAITB)
                     || (state == S_CMD2) || (state == S_CLOSE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_addr  <= '0;
            lat_wdata <= '0;
            lat_word  <= 1'b0;
            cyc_write <= 1'b0;
            wide      <= 1'b1;
            rdata     <= '0;
        end else begin
            if (start) begin
                cyc_addr  <= req_addr;
                lat_wdata <= req_wdata;
                lat_word  <= req_word;
                cyc_write <= req_write;
                if (!req_write)
                    rdata <= '0;
            end else if (state == S_CLOSE && need_split) begin
                cyc_addr <= cyc_addr | AD_W'(1);
            end
            if (state == S_ADDR)
                wide <= dyn_width_en ? bus_width : 1'b1;
            if (state == S_CMD2 && !cyc_write) begin
                if (xfer_word)
                    rdata <= ad_in;
                else if (second)
                    rdata[AD_W-1:BYTE_W] <= rd_byte;
                else
                    rdata[BYTE_W-1:0] <= rd_byte;
            end
        end
    end

    always_comb begin
        if (state == S_ADDR)
            ad_out = cyc_addr;
        else if (xfer_word)
            ad_out = lat_wdata;
        else
            ad_out = {wr_byte, wr_byte};
        ad_oe = (state == S_ADDR) || (cyc_write && in_cmd);
    end

    // the second part of a split always targets the odd byte
    assert_split_odd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && second) |-> cyc_addr[0]);

    // with dynamic width off, the cycle is always full width
    assert_width_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMD1 && !$past(dyn_width_en)) |-> wide);

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import mux_bus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_state_t state,
    input  logic       addr_mode,
    input  logic       strobe_mode,
    input  logic       cyc_write,
    input  logic       even_sel,
    input  logic       odd_sel,
    input  logic       need_split,
    output logic       addr_strobe,
    output logic       rd_n,
    output logic       wr_n,
    output logic       bhe_n,
    output logic       done
);

    logic cmd;

    always_comb begin
        cmd = (state == S_CMD1) || (state == S_WAITA) || (state == S_WAITB)
           || (state == S_CMD2);
        if (addr_mode)
            addr_strobe = (state == S_IDLE) || (state == S_CLOSE);
        else
            addr_strobe = (state == S_ADDR);
        rd_n  = !(cmd && !cyc_write);
        if (strobe_mode)
            wr_n = !(cmd && cyc_write && even_sel);
        else
            wr_n = !(cmd && cyc_write);
        bhe_n = !(cmd && cyc_write && odd_sel);
        done  = (state == S_CLOSE) && !need_split;
    end

    assert_rd_only_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cyc_write);

    assert_no_rd_wr_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mux_bus_pkg::*;
#(
    parameter int AD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_mode,
    input  logic            strobe_mode,
    input  logic            dyn_width_en,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_word,
    input  logic [AD_W-1:0] req_addr,
    input  logic [AD_W-1:0] req_wdata,
    input  logic            ready,
    input  logic            bus_width,
    input  logic [AD_W-1:0] ad_in,
    output logic [AD_W-1:0] ad_out,
    output logic            ad_oe,
    output logic            clk_out,
    output logic            addr_strobe,
    output logic            rd_n,
    output logic            wr_n,
    output logic            bhe_n,
    output logic [AD_W-1:0] rdata,
    output logic            done
);

    bus_state_t state;
    logic start, second, need_split;
    logic cyc_write, even_sel, odd_sel;

    bus_cycle_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .ready      (ready),
        .need_split (need_split),
        .state      (state),
        .clk_out    (clk_out),
        .start      (start),
        .second     (second)
    );

    bus_lane_path #(.AD_W(AD_W)) u_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .state        (state),
        .second       (second),
        .req_write    (req_write),
        .req_word     (req_word),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .dyn_width_en (dyn_width_en),
        .bus_width    (bus_width),
        .ad_in        (ad_in),
        .ad_out       (ad_out),
        .ad_oe        (ad_oe),
        .rdata        (rdata),
        .cyc_write    (cyc_write),
        .even_sel     (even_sel),
        .odd_sel      (odd_sel),
        .need_split   (need_split)
    );

    bus_strobe_gen u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .addr_mode   (addr_mode),
        .strobe_mode (strobe_mode),
        .cyc_write   (cyc_write),
        .even_sel    (even_sel),
        .odd_sel     (odd_sel),
        .need_split  (need_split),
        .addr_strobe (addr_strobe),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .bhe_n       (bhe_n),
        .done        (done)
    );

endmodule

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, addr_mode, strobe_mode, dyn_width_en;
    logic        req_valid, req_write, req_word;
    logic [15:0] req_addr, req_wdata;
    logic        ready, bus_width;
    logic [15:0] ad_in, ad_out, rdata;
    logic        ad_oe, clk_out, addr_strobe, rd_n, wr_n, bhe_n, done;

    mux_bus_seq i_mux_bus_seq (
        .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode), .strobe_mode(strobe_mode),
        .dyn_width_en(dyn_width_en), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .bus_width(bus_width), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .clk_out(clk_out), .addr_strobe(addr_strobe), .rd_n(rd_n),
        .wr_n(wr_n), .bhe_n(bhe_n), .rdata(rdata), .done(done)
    );

    int tests = 0;
    int fails = 0;

    logic [7:0] mem  [256];
    logic [7:0] refm [256];

    int force_w   = -1;
    int force_wid = -1;

    // transaction view shared with the bus model
    logic        cur_write, cur_word;
    logic [15:0] cur_wdata;
    int          phys_cnt;
    logic [15:0] seen_addr [2];
    logic        first_eff16;

    // per physical cycle
    logic [15:0] pa;
    logic        eff16;
    int          waits;
    int          lowcnt;
    logic        prev_lo = 1'b0;
    logic        prev_as = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // bus model: acts on falling edges only
    always @(negedge clk) begin
        logic       hit, lo, xw, ev, od;
        logic [7:0] a, b;
        if (rst_n) begin
            hit = addr_mode ? (prev_as && !addr_strobe) : addr_strobe;
            prev_as = addr_strobe;
            if (hit) begin
                chk(clk_out == 1'b1, "R3", "clk_out in address clock", clk_out, 1);
                chk(ad_oe == 1'b1, "R2", "bus driven in address clock", ad_oe, 1);
                pa = ad_out;
                if (phys_cnt < 2) seen_addr[phys_cnt] = ad_out;
                phys_cnt++;
                bus_width = (force_wid >= 0) ? force_wid[0] : 1'($urandom_range(0, 1));
                eff16 = dyn_width_en ? bus_width : 1'b1;
                if (phys_cnt == 1) first_eff16 = eff16;
                waits  = (force_w >= 0) ? force_w : $urandom_range(0, 3);
                lowcnt = 0;
                ready  = 1'b0;
            end
            lo = !rd_n || !wr_n || !bhe_n;
            a  = pa[7:0];
            xw = cur_word && eff16 && (phys_cnt == 1);
            ev = xw || !a[0];
            od = xw || a[0];
            if (lo) begin
                lowcnt++;
                ready = (lowcnt >= 1 + 2 * waits);
                if (lowcnt == 1) begin
                    if (!cur_write) begin
                        chk(!rd_n && wr_n && bhe_n, "R6", "read strobes",
                            {rd_n, wr_n, bhe_n}, 3'b011);
                    end else begin
                        chk(rd_n && (wr_n == (strobe_mode ? !ev : 1'b0)) && (bhe_n == !od),
                            strobe_mode ? "R8" : "R7", "write strobes",
                            {rd_n, wr_n, bhe_n},
                            {1'b1, (strobe_mode ? !ev : 1'b0), !od});
                        b = (phys_cnt == 2) ? cur_wdata[15:8] : cur_wdata[7:0];
                        chk(ad_oe && ad_out == (xw ? cur_wdata : {b, b}), "R11",
                            "write lanes", ad_out, xw ? cur_wdata : {b, b});
                    end
                end
                if (!cur_write) begin
                    if (eff16)
                        ad_in = {mem[a | 8'h01], mem[a & 8'hFE]};
                    else
                        ad_in = {8'($urandom), mem[a]};
                end else begin
                    if (eff16) begin
                        if (ev) mem[a & 8'hFE] = ad_out[7:0];
                        if (od) mem[a | 8'h01] = ad_out[15:8];
                    end else begin
                        mem[a] = ad_out[7:0];
                    end
                end
            end else if (prev_lo) begin
                chk(lowcnt == 2 + 2 * waits, "R4", "strobe-low clocks", lowcnt, 2 + 2 * waits);
            end
            prev_lo = lo;
        end
    end

    task automatic cfg(input logic am, input logic sm, input logic dy);
        @(negedge clk);
        addr_mode = am; strobe_mode = sm; dyn_width_en = dy;
        repeat (2) @(negedge clk);
    endtask

    task automatic txn(input logic w, input logic wd, input logic [15:0] addr,
                       input logic [15:0] data);
        bit got;
        logic [7:0] a;
        logic [15:0] exp;
        int ncyc;
        a = addr[7:0];
        @(negedge clk);
        cur_write = w; cur_word = wd; cur_wdata = data; phys_cnt = 0;
        req_write = w; req_word = wd; req_addr = addr; req_wdata = data; req_valid = 1'b1;
        got = 0;
        for (int i = 0; i < 400 && !got; i++) begin
            @(negedge clk);
            if (done) got = 1;
        end
        if (!got) begin
            chk(0, "R10", "done timeout", 0, 1);
            req_valid = 1'b0;
        end else begin
            req_valid = 1'b0;
            ncyc = (wd && !first_eff16) ? 2 : 1;
            chk(phys_cnt == ncyc, wd ? "R9" : "R5", "physical cycle count", phys_cnt, ncyc);
            chk(seen_addr[0] == addr, "R2", "first cycle address", seen_addr[0], addr);
            if (ncyc == 2)
                chk(seen_addr[1] == (addr | 16'h1), "R9", "second cycle address",
                    seen_addr[1], addr | 16'h1);
            if (!w) begin
                exp = wd ? {refm[a | 8'h01], refm[a]} : {8'h00, refm[a]};
                chk(rdata == exp, "R10", "read data at done", rdata, exp);
            end else begin
                refm[a] = data[7:0];
                if (wd) refm[a | 8'h01] = data[15:8];
                chk(mem[a] == refm[a], "R11", "written byte", mem[a], refm[a]);
                chk(mem[a ^ 8'h01] == refm[a ^ 8'h01], strobe_mode ? "R8" : "R7",
                    "neighbour byte", mem[a ^ 8'h01], refm[a ^ 8'h01]);
            end
            @(negedge clk);
            chk(done == 1'b0, "R10", "done single pulse", done, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: got 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; addr_mode = 1'b0; strobe_mode = 1'b0; dyn_width_en = 1'b1;
        req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
        req_addr = '0; req_wdata = '0; ready = 1'b1; bus_width = 1'b1; ad_in = '0;
        cur_write = 0; cur_word = 0; cur_wdata = 0; phys_cnt = 0;
        pa = 0; eff16 = 1; waits = 0; lowcnt = 0; first_eff16 = 1;
        seen_addr[0] = 0; seen_addr[1] = 0;
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'($urandom);
            refm[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_n == 1'b1, "R1", "rd_n in reset", rd_n, 1);
        chk(wr_n == 1'b1, "R1", "wr_n in reset", wr_n, 1);
        chk(bhe_n == 1'b1, "R1", "bhe_n in reset", bhe_n, 1);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(ad_oe == 1'b0, "R1", "ad_oe in reset", ad_oe, 0);
        chk(addr_strobe == 1'b0, "R1", "addr strobe in reset", addr_strobe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed: 8-bit splits (R9), both strobe encodings
        force_wid = 0; force_w = 0;
        cfg(0, 0, 1); txn(0, 1, 16'h0010, 16'h0);
        txn(1, 1, 16'h0020, 16'hA55A);
        cfg(0, 1, 1); txn(1, 1, 16'h0030, 16'h1234);
        txn(1, 0, 16'h0041, 16'h00C3);
        // directed: 16-bit lanes (R6, R8, R11)
        force_wid = 1;
        txn(1, 1, 16'h0050, 16'hBEEF);
        txn(1, 0, 16'h0053, 16'h007E);
        txn(1, 0, 16'h0054, 16'h0081);
        txn(0, 0, 16'h0053, 16'h0);
        txn(0, 1, 16'h0050, 16'h0);
        // directed: long waits (R4)
        force_w = 5;
        txn(0, 1, 16'h0060, 16'h0);
        txn(1, 0, 16'h0065, 16'h0042);
        // directed: fixed width ignores the pin (R5)
        force_wid = 0; force_w = 1;
        cfg(0, 0, 0); txn(0, 1, 16'h0070, 16'h0);
        // directed: address-valid style (R2) with a split write
        cfg(1, 1, 1); txn(1, 1, 16'h0080, 16'h5AA5);
        txn(0, 1, 16'h0080, 16'h0);

        // constrained random
        force_wid = -1; force_w = -1;
        for (int n = 0; n < 150; n++) begin
            logic wd;
            logic [15:0] ad;
            if (n % 25 == 0)
                cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    ($urandom_range(0, 3) != 0));
            wd = 1'($urandom_range(0, 1));
            ad = {8'h00, 8'($urandom)};
            if (wd) ad[0] = 1'b0;
            txn(1'($urandom_range(0, 1)), wd, ad, 16'($urandom));
        end

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule